// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block runs one programmed pass over an ordered list of analog channels and gathers the converted values. Software fills a list register with 4-bit channel numbers and sets the number of list positions to visit. It then writes a start bit. The sequencer asks an external converter for one conversion per position, in ascending position order. Each converter request carries a channel number and is held until the converter acknowledges it with a 12-bit value.

Every value is stored in a 16-entry result queue, tagged with the channel it came from. Software drains the queue through a dedicated pop port. Status bits record that the pass has ended and that a queue error (an overflow or an underflow) has happened. Software clears each status bit by writing 1 to it. A single interrupt line combines the enabled status conditions with a fill-level condition set against a programmable threshold.

The register bus has write-only strobes. Read data is combinational from `reg_addr`. Register offsets are: control 0x00, node count 0x04, node list 0x08, status 0x10, queue control 0x20. Every other offset reads as zero.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset every register reads zero, `conv_req` and `irq` are low, and `fifo_rdata` is zero.
- R2: Control bit 0 enables the block and bit 22 starts a pass. The start bit reads 1 until the pass begins, which is on the next clock edge, and then reads 0 on its own. A start written together with bit 0 clear is dropped, and no request follows.
- R3: The node-count register holds the number of positions minus one in its low bits. Position k of the node-list register sits in bits [4k+3:4k]. One request is issued per position, in ascending order. Each request holds its channel on `conv_ch` until `conv_ack`.
- R4: Each queue entry holds the conversion value in bits [11:0] and the channel number in bits [15:12]. Entries pop in the order they were pushed.
- R5: Status bit 0 is set on the edge that stores the last position's value. Writing 1 to the bit clears it. If that write falls on the same edge as the setting event, the bit stays set.
- R6: A start written while a pass is running is dropped. That pass produces no extra requests, and the start bit reads 0.
- R7: The queue holds 16 entries. A push into a full queue is dropped and sets the sticky overflow flag (queue control bit 16) and status bit 2.
- R8: A pop from an empty queue returns zero and sets the sticky underflow flag (queue control bit 17) and status bit 2.
- R9: Writing 1 to queue control bit 0 empties the queue and clears both sticky flags. A value pushed on that same edge is kept as the only entry.
- R10: `irq` is high while any of these holds: status bit 0 with control bit 18 set; status bit 2 with queue control bit 3 set; queue control bit 1 set and the entry count is nonzero and at least the threshold in queue control bits [12:8].
- R11: Clearing control bit 0 during a pass drops `conv_req` on the next cycle. The value of the pending node is not stored, and status bit 0 is not set.
- R12: Queue control bits [28:24] read the current number of stored entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| fifo_rd | input | 1 | Pop one queue entry on this edge |
| fifo_rdata | output | 16 | Head entry {channel, value}, zero when empty |
| conv_req | output | 1 | Conversion request |
| conv_ch | output | 4 | Channel to convert |
| conv_ack | input | 1 | Converter has produced `conv_data` |
| conv_data | input | 12 | Conversion value |
| irq | output | 1 | Combined interrupt |

## Verification
Two pairs of functions can land on the same edge. The first pair is the write-one-clear of the pass-complete bit and the setting of that bit by the last stored value. The second pair is a queue flush and a push of a fresh value. The bench uses a converter model with zero acknowledge latency, so the edge of every push is known in advance. It then aims the register write at the edge of the last push, or of the first push. It judges the result at the ports: the status bit must still read 1, and after a flush the entry count must equal only the values of the new pass, with the right contents.

// File: rtl/adcq_pkg.sv
package adcq_pkg;

    localparam int CH_W  = 4;
    localparam int RES_W = 12;

    typedef struct packed {
        logic [CH_W-1:0]  ch;
        logic [RES_W-1:0] res;
    } adcq_entry_t;

    localparam int ENTRY_W = $bits(adcq_entry_t);

    // register offsets
    localparam logic [7:0] ADDR_CTRL = 8'h00;
    localparam logic [7:0] ADDR_TCNT = 8'h04;
    localparam logic [7:0] ADDR_NODE = 8'h08;
    localparam logic [7:0] ADDR_STAT = 8'h10;
    localparam logic [7:0] ADDR_FCTL = 8'h20;

    // control bits
    localparam int CTRL_EN   = 0;
    localparam int CTRL_IE   = 18;
    localparam int CTRL_TRIG = 22;

    // status bits
    localparam int STAT_DONE = 0;
    localparam int STAT_FERR = 2;

    // queue control bits
    localparam int FCTL_FLUSH  = 0;
    localparam int FCTL_RDYIE  = 1;
    localparam int FCTL_ERRIE  = 3;
    localparam int FCTL_THR    = 8;
    localparam int FCTL_OF     = 16;
    localparam int FCTL_UF     = 17;
    localparam int FCTL_CNT    = 24;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_SCAN = 1'b1
    } seq_state_t;

    function automatic logic ptr_wrap_needed(input int unsigned ptr, input int unsigned depth);
        return ptr == depth - 1;
    endfunction

endpackage

// File: rtl/adcq_fifo.sv
module adcq_fifo
    import adcq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                flush_i,
    input  logic                                push_i,
    input  adcq_entry_t                         push_data_i,
    input  logic                                pop_i,
    output adcq_entry_t                         pop_data_o,
    output logic [$clog2(DEPTH+1)-1:0]          count_o,
    output logic                                of_o,
    output logic                                uf_o,
    output logic                                err_evt_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    adcq_entry_t      mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic [CNT_W-1:0] count_q;
    logic             of_q, uf_q;
    logic             full, empty, pop_ok, push_ok, ovf_evt, unf_evt;

    assign full    = (count_q == CNT_W'(DEPTH));
    assign empty   = (count_q == '0);
    assign pop_ok  = pop_i && !empty && !flush_i;
    assign push_ok = push_i && !flush_i && (!full || pop_ok);
    assign ovf_evt = push_i && full && !pop_ok && !flush_i;
    assign unf_evt = pop_i && empty && !flush_i;

    assign wr_nxt = ptr_wrap_needed(int'(wr_ptr), DEPTH) ? '0 : wr_ptr + 1'b1;
    assign rd_nxt = ptr_wrap_needed(int'(rd_ptr), DEPTH) ? '0 : rd_ptr + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
            of_q    <= 1'b0;
            uf_q    <= 1'b0;
        end else if (flush_i) begin
            rd_ptr <= '0;
            of_q   <= 1'b0;
            uf_q   <= 1'b0;
            if (push_i) begin
                wr_ptr  <= PTR_W'(1 % DEPTH);
                count_q <= CNT_W'(1);
            end else begin
                wr_ptr  <= '0;
                count_q <= '0;
            end
        end else begin
            if (push_ok) wr_ptr <= wr_nxt;
            if (pop_ok)  rd_ptr <= rd_nxt;
            count_q <= count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
            of_q    <= of_q | ovf_evt;
            uf_q    <= uf_q | unf_evt;
        end
    end

    always_ff @(posedge clk) begin
        if (flush_i && push_i)
            mem[0] <= push_data_i;
        else if (push_ok)
            mem[wr_ptr] <= push_data_i;
    end

    assign pop_data_o = empty ? '0 : mem[rd_ptr];
    assign count_o    = count_q;
    assign of_o       = of_q;
    assign uf_o       = uf_q;
    assign err_evt_o  = ovf_evt | unf_evt;

    // R7: stored count never exceeds the depth
    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH));

    // R7: a push into a full queue leaves it full and flags overflow
    a_r7_full_drop: assert property (@(posedge clk) disable iff (rst)
        (push_i && full && !pop_i && !flush_i) |=> (count_q == CNT_W'(DEPTH)) && of_q);

    // R8: a pop of an empty queue flags underflow
    a_r8_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (pop_i && empty && !flush_i) |=> uf_q);

    // R9: a flush leaves at most the same-edge push and clears both flags
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (count_q <= CNT_W'(1)) && !of_q && !uf_q);

endmodule

// File: rtl/adcq_sequencer.sv
module adcq_sequencer
    import adcq_pkg::*;
#(
    parameter int NODES = 8
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic                                     en_i,
    input  logic                                     start_i,
    input  logic [NODES*CH_W-1:0]                    node_list_i,
    input  logic [((NODES > 1) ? $clog2(NODES) : 1)-1:0] last_i,
    input  logic                                     conv_ack_i,
    input  logic [RES_W-1:0]                         conv_data_i,
    output logic                                     conv_req_o,
    output logic [CH_W-1:0]                          conv_ch_o,
    output logic                                     push_o,
    output adcq_entry_t                              push_data_o,
    output logic                                     done_o,
    output logic                                     start_o,
    output logic                                     busy_o
);
    localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1;

    seq_state_t       state_q;
    logic [IDX_W-1:0] idx_q, last_eff;
    logic [CH_W-1:0]  slot [NODES];
    logic             scan_live, at_last;

    for (genvar g = 0; g < NODES; g++) begin : g_slot
        assign slot[g] = node_list_i[g*CH_W +: CH_W];
    end

    assign last_eff  = (int'(last_i) > NODES - 1) ? IDX_W'(NODES - 1) : last_i;
    assign at_last   = (idx_q == last_eff);
    assign scan_live = (state_q == SEQ_SCAN) && en_i;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    idx_q <= '0;
                    if (start_i) state_q <= SEQ_SCAN;
                end
                SEQ_SCAN: begin
                    if (conv_ack_i) begin
                        if (at_last) begin
                            state_q <= SEQ_IDLE;
                            idx_q   <= '0;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign conv_req_o      = scan_live;
    assign conv_ch_o       = slot[idx_q];
    assign push_o          = scan_live && conv_ack_i;
    assign push_data_o.ch  = slot[idx_q];
    assign push_data_o.res = conv_data_i;
    assign done_o          = scan_live && conv_ack_i && at_last;
    assign start_o         = (state_q == SEQ_IDLE) && start_i && en_i;
    assign busy_o          = (state_q == SEQ_SCAN);

    // R3: an unanswered request keeps its channel into the next cycle
    a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
        (conv_req_o && !conv_ack_i && en_i) |=> (!en_i || (conv_req_o && $stable(conv_ch_o))));

    // R5: the pass ends after the last stored value
    a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

    // R2: an accepted start leads to a request
    a_r2_start_req: assert property (@(posedge clk) disable iff (rst)
        start_o |=> (busy_o && (conv_req_o || !en_i)));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adcq_pkg::*;
#(
    parameter int NODES      = 8,
    parameter int FIFO_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        fifo_rd,
    output logic [15:0] fifo_rdata,
    output logic        conv_req,
    output logic [3:0]  conv_ch,
    input  logic        conv_ack,
    input  logic [11:0] conv_data,
    output logic        irq
);
    localparam int IDX_W  = (NODES > 1) ? $clog2(NODES) : 1;
    localparam int LIST_W = NODES * CH_W;
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);

    logic              ctrl_en, ctrl_ie, trig_q;
    logic [IDX_W-1:0]  tcnt_q;
    logic [LIST_W-1:0] node_q;
    logic              stat_done, stat_ferr;
    logic [CNT_W-1:0]  thr_q;
    logic              rdyie_q, errie_q;

    logic wr_ctrl, wr_tcnt, wr_node, wr_stat, wr_fctl, flush;
    logic seq_push, seq_done, seq_start, seq_busy;
    adcq_entry_t      push_data, head;
    logic [CNT_W-1:0] fifo_cnt;
    logic             fifo_of, fifo_uf, fifo_err;
    logic             ready;

    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_tcnt = reg_wr && (reg_addr == ADDR_TCNT);
    assign wr_node = reg_wr && (reg_addr == ADDR_NODE);
    assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
    assign wr_fctl = reg_wr && (reg_addr == ADDR_FCTL);
    assign flush   = wr_fctl && reg_wdata[FCTL_FLUSH];

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en <= 1'b0;
            ctrl_ie <= 1'b0;
            tcnt_q  <= '0;
            node_q  <= '0;
            thr_q   <= '0;
            rdyie_q <= 1'b0;
            errie_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_en <= reg_wdata[CTRL_EN];
                ctrl_ie <= reg_wdata[CTRL_IE];
            end
            if (wr_tcnt) tcnt_q <= reg_wdata[IDX_W-1:0];
            if (wr_node) node_q <= reg_wdata[LIST_W-1:0];
            if (wr_fctl) begin
                thr_q   <= reg_wdata[FCTL_THR +: CNT_W];
                rdyie_q <= reg_wdata[FCTL_RDYIE];
                errie_q <= reg_wdata[FCTL_ERRIE];
            end
        end
    end

    // start request: taken only when enabled and idle, cleared when the pass begins
    always_ff @(posedge clk) begin
        if (rst)
            trig_q <= 1'b0;
        else if (seq_start)
            trig_q <= 1'b0;
        else if (wr_ctrl)
            trig_q <= reg_wdata[CTRL_TRIG] && reg_wdata[CTRL_EN] && !seq_busy;
    end

    // status: setting event wins over a same-edge clear
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_done <= 1'b0;
            stat_ferr <= 1'b0;
        end else begin
            stat_done <= (stat_done && !(wr_stat && reg_wdata[STAT_DONE])) || seq_done;
            stat_ferr <= (stat_ferr && !(wr_stat && reg_wdata[STAT_FERR])) || fifo_err;
        end
    end

    adcq_sequencer #(
        .NODES (NODES)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .en_i        (ctrl_en),
        .start_i     (trig_q),
        .node_list_i (node_q),
        .last_i      (tcnt_q),
        .conv_ack_i  (conv_ack),
        .conv_data_i (conv_data),
        .conv_req_o  (conv_req),
        .conv_ch_o   (conv_ch),
        .push_o      (seq_push),
        .push_data_o (push_data),
        .done_o      (seq_done),
        .start_o     (seq_start),
        .busy_o      (seq_busy)
    );

    adcq_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk         (clk),
        .rst         (rst),
        .flush_i     (flush),
        .push_i      (seq_push),
        .push_data_i (push_data),
        .pop_i       (fifo_rd),
        .pop_data_o  (head),
        .count_o     (fifo_cnt),
        .of_o        (fifo_of),
        .uf_o        (fifo_uf),
        .err_evt_o   (fifo_err)
    );

    assign fifo_rdata = head;

    // read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CTRL_EN]   = ctrl_en;
                reg_rdata[CTRL_IE]   = ctrl_ie;
                reg_rdata[CTRL_TRIG] = trig_q;
            end
            ADDR_TCNT: reg_rdata[IDX_W-1:0] = tcnt_q;
            ADDR_NODE: reg_rdata[LIST_W-1:0] = node_q;
            ADDR_STAT: begin
                reg_rdata[STAT_DONE] = stat_done;
                reg_rdata[STAT_FERR] = stat_ferr;
            end
            ADDR_FCTL: begin
                reg_rdata[FCTL_RDYIE]        = rdyie_q;
                reg_rdata[FCTL_ERRIE]        = errie_q;
                reg_rdata[FCTL_THR +: CNT_W] = thr_q;
                reg_rdata[FCTL_OF]           = fifo_of;
                reg_rdata[FCTL_UF]           = fifo_uf;
                reg_rdata[FCTL_CNT +: CNT_W] = fifo_cnt;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign ready = rdyie_q && (fifo_cnt != '0) && (fifo_cnt >= thr_q);
    assign irq   = (stat_done && ctrl_ie) || (stat_ferr && errie_q) || ready;

    // R5: the last stored value always leaves the complete bit set
    a_r5_done_sets: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> stat_done);

    // R2: the start bit is gone once the pass has begun
    a_r2_trig_clears: assert property (@(posedge clk) disable iff (rst)
        seq_start |=> !trig_q);

    // R6: a start written during a pass is not kept
    a_r6_busy_trig: assert property (@(posedge clk) disable iff (rst)
        (seq_busy && wr_ctrl && !seq_start) |=> !trig_q);

    // R7: a queue error event always reaches the status bit
    a_r7_err_status: assert property (@(posedge clk) disable iff (rst)
        fifo_err |=> stat_ferr);

endmodule

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;

    localparam int CLK_PERIOD = 10;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_TCNT = 8'h04;
    localparam logic [7:0] A_NODE = 8'h08;
    localparam logic [7:0] A_STAT = 8'h10;
    localparam logic [7:0] A_FCTL = 8'h20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fifo_rd = 1'b0;
    logic [15:0] fifo_rdata;
    logic        conv_req;
    logic [3:0]  conv_ch;
    logic        conv_ack = 1'b0;
    logic [11:0] conv_data = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    int ack_lat = 0;
    int wait_cnt = 0;
    int n_conv = 0;
    int exp_n = 0;
    logic [15:0] exp_e [0:63];

    adc_scan_seq dut (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .fifo_rd    (fifo_rd),
        .fifo_rdata (fifo_rdata),
        .conv_req   (conv_req),
        .conv_ch    (conv_ch),
        .conv_ack   (conv_ack),
        .conv_data  (conv_data),
        .irq        (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // converter model: answers after ack_lat idle cycles, records what it returned
    always @(negedge clk) begin
        if (conv_req) begin
            if (wait_cnt >= ack_lat) begin
                logic [11:0] v;
                v = 12'((100 + 37 * int'(conv_ch) + 5 * n_conv) % 4096);
                conv_ack  = 1'b1;
                conv_data = v;
                if (exp_n < 64) exp_e[exp_n] = {conv_ch, v};
                exp_n++;
                n_conv++;
                wait_cnt = 0;
            end else begin
                conv_ack = 1'b0;
                wait_cnt++;
            end
        end else begin
            conv_ack = 1'b0;
            wait_cnt = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pop(output logic [15:0] d);
        d = fifo_rdata;
        fifo_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        fifo_rd = 1'b0;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            rd(A_STAT, s);
            if (s[0]) break;
        end
    endtask

    task automatic prepare();
        wr(A_CTRL, 32'h1);
        wr(A_FCTL, 32'h1);
        wr(A_STAT, 32'h5);
        @(negedge clk);
        exp_n = 0; n_conv = 0;
    endtask

    function automatic logic [31:0] cnt_of(input logic [31:0] f);
        return 32'(f[28:24]);
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(A_CTRL, d); chk("R1 ctrl", d, 0);
        rd(A_TCNT, d); chk("R1 tcnt", d, 0);
        rd(A_NODE, d); chk("R1 node", d, 0);
        rd(A_STAT, d); chk("R1 stat", d, 0);
        rd(A_FCTL, d); chk("R1 fctl", d, 0);
        chk("R1 req", 32'(conv_req), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 fifo_rdata", 32'(fifo_rdata), 0);
    endtask

    task automatic t_basic();
        logic [31:0] d;
        logic [15:0] e;
        logic [3:0] chs [5] = '{4'h2, 4'hF, 4'h1, 4'h5, 4'hC};
        prepare(); ack_lat = 2;
        wr(A_NODE, 32'h7A3C51F2);
        wr(A_TCNT, 32'd4);
        wr(A_CTRL, 32'h0040_0001);
        wait_done();
        rd(A_CTRL, d); chk("R2 trig self-clear", 32'(d[22]), 0);
        chk("R3 conversion count", n_conv, 5);
        for (int i = 0; i < 5; i++) chk("R3 channel order", 32'(exp_e[i][15:12]), 32'(chs[i]));
        rd(A_FCTL, d); chk("R12 entry count", cnt_of(d), 5);
        rd(A_STAT, d); chk("R5 done set", 32'(d[0]), 1);
        for (int i = 0; i < 5; i++) begin
            pop(e); chk("R4 entry", 32'(e), 32'(exp_e[i]));
        end
        wr(A_STAT, 32'h1);
        rd(A_STAT, d); chk("R5 w1c", 32'(d[0]), 0);
    endtask

    task automatic t_single();
        logic [15:0] e;
        prepare(); ack_lat = 1;
        wr(A_NODE, 32'h0000_0009);
        wr(A_TCNT, 32'd0);
        wr(A_CTRL, 32'h0040_0001);
        wait_done();
        repeat (5) @(negedge clk);
        chk("R3 single node count", n_conv, 1);
        pop(e);
        chk("R4 single entry", 32'(e), 32'(exp_e[0]));
        chk("R3 single channel", 32'(e[15:12]), 32'h9);
    endtask

    task automatic t_busy_trig();
        logic [31:0] d;
        prepare(); ack_lat = 4;
        wr(A_NODE, 32'h0000_0321);
        wr(A_TCNT, 32'd2);
        wr(A_CTRL, 32'h0040_0001);
        repeat (3) @(negedge clk);
        wr(A_CTRL, 32'h0040_0001);
        rd(A_CTRL, d); chk("R6 trig dropped while busy", 32'(d[22]), 0);
        wait_done();
        repeat (30) @(negedge clk);
        chk("R6 no extra conversions", n_conv, 3);
        chk("R6 request idle", 32'(conv_req), 0);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        prepare(); ack_lat = 0;
        wr(A_NODE, 32'h0000_0001);
        wr(A_TCNT, 32'd0);
        wr(A_CTRL, 32'h0040_0000);
        rd(A_CTRL, d); chk("R2 trig dropped when disabled", 32'(d[22]), 0);
        repeat (10) @(negedge clk);
        chk("R2 no conversion when disabled", n_conv, 0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        prepare(); ack_lat = 0;
        wr(A_NODE, 32'h0000_00AB);
        wr(A_TCNT, 32'd1);
        wr(A_CTRL, 32'h0040_0001);
        repeat (2) @(negedge clk);
        wr(A_STAT, 32'h1);          // lands on the edge of the last push
        rd(A_STAT, d); chk("R5 set wins over clear", 32'(d[0]), 1);
        rd(A_FCTL, d); chk("R12 count after collide", cnt_of(d), 2);
        wr(A_STAT, 32'h1);
        rd(A_STAT, d); chk("R5 later clear", 32'(d[0]), 0);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        logic [15:0] e;
        prepare(); ack_lat = 0;
        wr(A_FCTL, 32'h8);
        wr(A_NODE, 32'h7654_3210);
        wr(A_TCNT, 32'd7);
        for (int s = 0; s < 3; s++) begin
            wr(A_CTRL, 32'h0040_0001);
            wait_done();
            wr(A_STAT, 32'h1);
        end
        rd(A_FCTL, d);
        chk("R7 count full", cnt_of(d), 16);
        chk("R7 overflow flag", 32'(d[16]), 1);
        rd(A_STAT, d); chk("R7 status error", 32'(d[2]), 1);
        chk("R10 error irq", 32'(irq), 1);
        for (int i = 0; i < 16; i++) begin
            pop(e); chk("R7 kept entries", 32'(e), 32'(exp_e[i]));
        end
        rd(A_FCTL, d); chk("R12 drained", cnt_of(d), 0);
        // underflow
        wr(A_STAT, 32'h4);
        pop(e); chk("R8 empty read zero", 32'(e), 0);
        rd(A_FCTL, d); chk("R8 underflow flag", 32'(d[17]), 1);
        rd(A_STAT, d); chk("R8 status error", 32'(d[2]), 1);
        // flush clears flags
        wr(A_FCTL, 32'h9);
        rd(A_FCTL, d);
        chk("R9 flags cleared", 32'(d[17:16]), 0);
        chk("R9 count zero", cnt_of(d), 0);
        wr(A_STAT, 32'h4);
        chk("R10 irq low after clear", 32'(irq), 0);
    endtask

    task automatic t_flush_push();
        logic [31:0] d;
        logic [15:0] e;
        prepare(); ack_lat = 0;
        wr(A_NODE, 32'h0000_0021);
        wr(A_TCNT, 32'd1);
        wr(A_CTRL, 32'h0040_0001);
        wait_done();
        wr(A_STAT, 32'h1);
        wr(A_NODE, 32'h0000_0D5E);
        wr(A_TCNT, 32'd2);
        exp_n = 0;
        wr(A_CTRL, 32'h0040_0001);
        @(negedge clk);
        wr(A_FCTL, 32'h1);          // lands on the edge of the first push
        wait_done();
        rd(A_FCTL, d); chk("R9 flush keeps same-edge push", cnt_of(d), 3);
        for (int i = 0; i < 3; i++) begin
            pop(e); chk("R9 entries after flush", 32'(e), 32'(exp_e[i]));
        end
    endtask

    task automatic t_irq();
        prepare(); ack_lat = 0;
        wr(A_FCTL, 32'h0000_0302);
        wr(A_NODE, 32'h0000_0054);
        wr(A_TCNT, 32'd1);
        wr(A_CTRL, 32'h0040_0001);
        wait_done();
        @(negedge clk);
        chk("R10 below threshold", 32'(irq), 0);
        wr(A_STAT, 32'h1);
        wr(A_TCNT, 32'd0);
        wr(A_CTRL, 32'h0040_0001);
        wait_done();
        @(negedge clk);
        chk("R10 threshold reached", 32'(irq), 1);
        wr(A_FCTL, 32'h0);
        chk("R10 ready disabled", 32'(irq), 0);
        wr(A_CTRL, 32'h0004_0001);
        chk("R10 done irq", 32'(irq), 1);
        wr(A_STAT, 32'h1);
        chk("R10 done irq cleared", 32'(irq), 0);
        wr(A_CTRL, 32'h1);
    endtask

    task automatic t_abort();
        logic [31:0] d;
        prepare(); ack_lat = 6;
        wr(A_NODE, 32'h0000_4321);
        wr(A_TCNT, 32'd3);
        wr(A_CTRL, 32'h0040_0001);
        repeat (4) @(negedge clk);
        chk("R11 request active", 32'(conv_req), 1);
        wr(A_CTRL, 32'h0);
        chk("R11 request dropped", 32'(conv_req), 0);
        repeat (20) @(negedge clk);
        chk("R11 stays idle", 32'(conv_req), 0);
        rd(A_STAT, d); chk("R11 no done", 32'(d[0]), 0);
        rd(A_FCTL, d); chk("R11 nothing stored", cnt_of(d), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_single();
        t_busy_trig();
        t_disabled();
        t_collide();
        t_overflow();
        t_flush_push();
        t_irq();
        t_abort();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule